// File: doc/BRIEF.md
# Serial Chip-Select Guard Timer

This block owns the active-low chip-select line of a serial flash or peripheral port. It does not generate the serial clock or the data. It receives a half-period tick from the clock divider and places the select edges around each transfer, counting every interval in those ticks. A requester raises `start_req`. The block pulls select low and waits out a programmable setup lead. It then pulses `clk_go`, which tells the clock generator it may produce the first rising edge. When the clock generator reports the final rising edge on `xfer_done`, the block holds select low for the configured release delay. It then keeps select high for at least the configured minimum gap before any new assertion.

Release can be stretched to 32 or 128 serial-clock periods, or held off indefinitely. With a long or infinite release, a request that arrives while select is still low continues the open transaction. The block pulses `resume` and does not toggle the line, so a following read needs no new command phase. An indefinitely held select ends only when `force_release` is raised. The line then rises on the next tick and the normal gap follows.

Each interval is loaded when its phase starts: setup lead at assertion, release delay at `xfer_done`, gap at deassertion. Configuration fields must therefore be stable only at those points.

Top module: `cs_guard_ctrl`

## Requirements
- R1: After synchronous reset `cs_n` is 1 and `clk_go` and `resume` are 0. Select stays high while no request is present.
- R2: With `cfg_lead_long`=0, `clk_go` pulses for exactly one cycle after 1 tick has elapsed with `cs_n` low. With `cfg_lead_long`=1 it pulses after 3 ticks.
- R3: After `xfer_done`, `cs_n` rises after a number of ticks set by `cfg_release`: code 0 gives 1 tick, code 1 gives 3, code 2 gives 2*HOLD_A_CLKS (64), and code 3 gives 2*HOLD_B_CLKS (256). The rise always coincides with a tick.
- R4: `cfg_release` codes 4 to 7 mean never release: `cs_n` stays low after `xfer_done` for as long as `force_release` stays low.
- R5: While select is held after `xfer_done`, raising `force_release` makes `cs_n` rise on the first tick it sees. The minimum gap of R6 then applies.
- R6: After each rise, `cs_n` stays high for 2*(`cfg_gap`+1) ticks before it can fall again. `cfg_gap` holds the period count minus one. A request raised during the gap is served as soon as the gap ends.
- R7: A request that arrives during the hold phase, with release code 2 to 7, produces a one-cycle `resume` pulse. `cs_n` does not change and no `clk_go` pulse follows. The next `xfer_done` restarts the full release delay.
- R8: A request that arrives during the hold phase with release code 0 or 1 does not shorten or extend the release. It produces no `resume` pulse and is served after the gap.
- R9: `force_release` has no effect while select is idle-high or while a transfer is active. In the hold phase it takes priority over a pending continuation request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per serial-clock half period |
| start_req | input | 1 | Transfer request, held until `clk_go` or `resume` |
| xfer_done | input | 1 | Pulse: last rising serial-clock edge has been issued |
| force_release | input | 1 | Level: release a held select on the next tick |
| cfg_lead_long | input | 1 | Setup lead: 0 gives 1 tick, 1 gives 3 ticks |
| cfg_release | input | 3 | Release code: 0 gives 1 tick, 1 gives 3, 2 gives 64, 3 gives 256, 4 to 7 mean never |
| cfg_gap | input | GAP_W | Minimum high time in serial-clock periods, minus one |
| cs_n | output | 1 | Active-low chip select, registered |
| clk_go | output | 1 | One-cycle pulse: the serial clock may start |
| resume | output | 1 | One-cycle pulse: held transaction continues |

## Verification
A wrong phase count shows directly as a misplaced select edge or `clk_go` pulse. It is visible at the first transfer that uses the affected code, within at most 256 ticks. A wrong hold-phase latch of the release mode shows as either an early rise or a missing `resume` on the next request. A wrong priority between force and continuation shows as a `resume` pulse in place of a select rise. The bench times each interval by counting the ticks it observes between port events and compares them with tick counts derived from the codes.

// File: rtl/cs_guard_pkg.sv
`timescale 1ns/1ps
package cs_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_GAP    = 3'd4
  } cs_state_e;

  // Release codes; any code with bit 2 set holds select indefinitely
  localparam logic [2:0] REL_SHORT  = 3'd0;
  localparam logic [2:0] REL_MID    = 3'd1;
  localparam logic [2:0] REL_LONG_A = 3'd2;
  localparam logic [2:0] REL_LONG_B = 3'd3;

  function automatic logic rel_is_never(input logic [2:0] code);
    return code[2];
  endfunction

endpackage

// File: rtl/cs_guard_decode.sv
`timescale 1ns/1ps
module cs_guard_decode
  import cs_guard_pkg::*;
#(
  parameter int GAP_W       = 4,
  parameter int HOLD_A_CLKS = 32,
  parameter int HOLD_B_CLKS = 128,
  parameter int CNT_W       = 9
) (
  input  logic             lead_long,
  input  logic [2:0]       rel_code,
  input  logic [GAP_W-1:0] gap_code,
  output logic [CNT_W-1:0] lead_ticks,
  output logic [CNT_W-1:0] rel_ticks,
  output logic [CNT_W-1:0] gap_ticks,
  output logic             rel_never,
  output logic             rel_long
);

  always_comb begin
    lead_ticks = lead_long ? CNT_W'(3) : CNT_W'(1);
    rel_never  = rel_is_never(rel_code);
    rel_long   = rel_never || (rel_code == REL_LONG_A) || (rel_code == REL_LONG_B);
    case (rel_code)
      REL_SHORT:  rel_ticks = CNT_W'(1);
      REL_MID:    rel_ticks = CNT_W'(3);
      REL_LONG_A: rel_ticks = CNT_W'(2 * HOLD_A_CLKS);
      REL_LONG_B: rel_ticks = CNT_W'(2 * HOLD_B_CLKS);
      default:    rel_ticks = '0;
    endcase
    // periods = code + 1, two ticks per period
    gap_ticks = CNT_W'({gap_code, 1'b0}) + CNT_W'(2);
  end

endmodule

// File: rtl/cs_tick_counter.sv
`timescale 1ns/1ps
module cs_tick_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/cs_guard_ctrl.sv
`timescale 1ns/1ps
module cs_guard_ctrl
  import cs_guard_pkg::*;
#(
  parameter int GAP_W       = 4,
  parameter int HOLD_A_CLKS = 32,
  parameter int HOLD_B_CLKS = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start_req,
  input  logic             xfer_done,
  input  logic             force_release,
  input  logic             cfg_lead_long,
  input  logic [2:0]       cfg_release,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             cs_n,
  output logic             clk_go,
  output logic             resume
);

  localparam int MAX_TICKS = (2 * HOLD_B_CLKS > (2 << GAP_W)) ? 2 * HOLD_B_CLKS : (2 << GAP_W);
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  cs_state_e        st_q, st_d;
  logic             long_q, never_q;
  logic [CNT_W-1:0] lead_ticks, rel_ticks, gap_ticks;
  logic             rel_never, rel_long;
  logic             cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt_val;

  cs_guard_decode #(
    .GAP_W      (GAP_W),
    .HOLD_A_CLKS(HOLD_A_CLKS),
    .HOLD_B_CLKS(HOLD_B_CLKS),
    .CNT_W      (CNT_W)
  ) u_decode (
    .lead_long (cfg_lead_long),
    .rel_code  (cfg_release),
    .gap_code  (cfg_gap),
    .lead_ticks(lead_ticks),
    .rel_ticks (rel_ticks),
    .gap_ticks (gap_ticks),
    .rel_never (rel_never),
    .rel_long  (rel_long)
  );

  cs_tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .dec     (cnt_dec),
    .last    (cnt_last)
  );

  // next phase
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start_req) st_d = ST_SETUP;
      ST_SETUP:  if (tick && cnt_last) st_d = ST_ACTIVE;
      ST_ACTIVE: if (xfer_done) st_d = ST_HOLD;
      ST_HOLD: begin
        if (force_release) begin
          if (tick) st_d = ST_GAP;
        end else if (start_req && long_q) begin
          st_d = ST_ACTIVE;
        end else if (tick && !never_q && cnt_last) begin
          st_d = ST_GAP;
        end
      end
      ST_GAP:    if (tick && cnt_last) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // interval loading on phase entry, counting on ticks
  always_comb begin
    cnt_val = '0;
    case (st_d)
      ST_SETUP: cnt_val = lead_ticks;
      ST_HOLD:  cnt_val = rel_ticks;
      ST_GAP:   cnt_val = gap_ticks;
      default:  cnt_val = '0;
    endcase
    cnt_load = (st_d != st_q) &&
               ((st_d == ST_SETUP) || (st_d == ST_HOLD) || (st_d == ST_GAP));
    cnt_dec  = tick && ((st_q == ST_SETUP) || (st_q == ST_HOLD) || (st_q == ST_GAP));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      long_q  <= 1'b0;
      never_q <= 1'b0;
      cs_n    <= 1'b1;
      clk_go  <= 1'b0;
      resume  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n   <= !((st_d == ST_SETUP) || (st_d == ST_ACTIVE) || (st_d == ST_HOLD));
      clk_go <= (st_q == ST_SETUP) && (st_d == ST_ACTIVE);
      resume <= (st_q == ST_HOLD) && (st_d == ST_ACTIVE);
      if ((st_q == ST_ACTIVE) && (st_d == ST_HOLD)) begin
        long_q  <= rel_long;
        never_q <= rel_never;
      end
    end
  end

endmodule

// File: rtl/cs_guard_ctrl_chk.sv
`timescale 1ns/1ps
module cs_guard_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic start_req,
  input logic cs_n,
  input logic clk_go,
  input logic resume
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (cs_n && !clk_go && !resume)); // R1
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) clk_go |=> !clk_go); // R2
  AST_GO_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst) clk_go |-> !cs_n); // R2
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> $past(tick)); // R3
  AST_FALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> $past(start_req)); // R6
  AST_RESUME_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst) resume |-> (!cs_n && $past(!cs_n))); // R7
  AST_GO_RESUME_EXCL: assert property (@(posedge clk) disable iff (rst) !(clk_go && resume)); // R7

endmodule

bind cs_guard_ctrl cs_guard_ctrl_chk u_cs_guard_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .start_req(start_req),
  .cs_n     (cs_n),
  .clk_go   (clk_go),
  .resume   (resume)
);

// File: tb/cs_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module cs_guard_ctrl_tb_top;

  localparam int GAP_W = 4;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst, tick, start_req, xfer_done, force_release, cfg_lead_long;
  logic [2:0] cfg_release;
  logic [GAP_W-1:0] cfg_gap;
  logic cs_n, clk_go, resume;

  int n_tests = 0, n_fail = 0;
  int tk = 0, prev_cs = 1, done_pend = 0;
  int setup_ticks = 0, rel_ticks = 0, gap_ticks = 0;
  int n_fall = 0, n_rise = 0, n_go = 0, n_res = 0;
  int tdiv = 0;

  always #10 clk = ~clk;

  cs_guard_ctrl #(.GAP_W(GAP_W), .HOLD_A_CLKS(32), .HOLD_B_CLKS(128)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .start_req(start_req), .xfer_done(xfer_done),
    .force_release(force_release), .cfg_lead_long(cfg_lead_long), .cfg_release(cfg_release),
    .cfg_gap(cfg_gap), .cs_n(cs_n), .clk_go(clk_go), .resume(resume)
  );

  // half-period tick: one pulse every third cycle
  initial begin
    tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      tick = (tdiv == 2);
    end
  end

  // port monitor: ticks seen between select/go/done events
  always @(negedge clk) begin
    if (rst) begin
      tk = 0; prev_cs = 1; done_pend = 0;
    end else begin
      automatic bit ev = 0;
      if (!cs_n && prev_cs == 1) begin gap_ticks = tk; n_fall++; ev = 1; end
      if (cs_n && prev_cs == 0) begin rel_ticks = tk; n_rise++; ev = 1; end
      if (clk_go) begin setup_ticks = tk; n_go++; ev = 1; end
      if (resume) n_res++;
      if (done_pend != 0) ev = 1;
      done_pend = xfer_done ? 1 : 0;
      if (ev) tk = 0;
      if (tick) tk++;
      prev_cs = cs_n ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lead(input int l);
    return (l != 0) ? 3 : 1;
  endfunction

  function automatic int exp_rel(input int r);
    case (r)
      0: return 1;
      1: return 3;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  task automatic start_xfer(input int l, input int r, input int g);
    int og;
    @(posedge clk); #1;
    cfg_lead_long = l[0]; cfg_release = r[2:0]; cfg_gap = g[GAP_W-1:0];
    og = n_go;
    start_req = 1'b1;
    while (n_go == og) @(posedge clk);
    chk(setup_ticks == exp_lead(l), "R2 setup lead", setup_ticks, exp_lead(l));
    #1 start_req = 1'b0;
  endtask

  task automatic pulse_done(input bit re_req);
    repeat (2) @(posedge clk);
    #1 xfer_done = 1'b1;
    @(posedge clk);
    #1 xfer_done = 1'b0;
    if (re_req) start_req = 1'b1;
  endtask

  task automatic wait_rise(input int orr);
    while (n_rise == orr) @(posedge clk);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int prev_g, of, orr, oc, og, ft;
    rst = 1'b1; start_req = 1'b0; xfer_done = 1'b0; force_release = 1'b0;
    cfg_lead_long = 1'b0; cfg_release = 3'd0; cfg_gap = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n === 1'b1 && clk_go === 1'b0 && resume === 1'b0, "R1 reset state",
        int'({cs_n, clk_go, resume}), 4);
    @(posedge clk); #1 rst = 1'b0;
    repeat (12) @(posedge clk);
    chk(cs_n === 1'b1 && n_fall == 0, "R1 idle without request", n_fall, 0);

    // sweep: every gap, lead and short release, chained with requests in hold (R8)
    prev_g = -1;
    for (int g = 0; g < 16; g++) begin
      for (int l = 0; l < 2; l++) begin
        for (int r = 0; r < 2; r++) begin
          automatic bit last = (g == 15 && l == 1 && r == 1);
          @(posedge clk); #1;
          cfg_lead_long = l[0]; cfg_release = r[2:0]; cfg_gap = g[GAP_W-1:0];
          start_req = 1'b1;
          of = n_fall; og = n_go;
          while (n_fall == of) @(posedge clk);
          if (prev_g >= 0)
            chk(gap_ticks == 2 * (prev_g + 1), "R6 minimum high time", gap_ticks, 2 * (prev_g + 1));
          while (n_go == og) @(posedge clk);
          chk(setup_ticks == exp_lead(l), "R2 setup lead", setup_ticks, exp_lead(l));
          #1 start_req = 1'b0;
          oc = n_res; orr = n_rise;
          pulse_done(!last);
          wait_rise(orr);
          chk(rel_ticks == exp_rel(r), "R3 short release", rel_ticks, exp_rel(r));
          chk(n_res == oc, "R8 request in short hold ignored", n_res - oc, 0);
          prev_g = g;
        end
      end
    end
    @(posedge clk); #1 start_req = 1'b0;
    repeat (150) @(posedge clk);

    // long releases
    for (int l = 0; l < 2; l++) begin
      for (int r = 2; r < 4; r++) begin
        start_xfer(l, r, 0);
        orr = n_rise;
        pulse_done(1'b0);
        wait_rise(orr);
        chk(rel_ticks == exp_rel(r), "R3 long release", rel_ticks, exp_rel(r));
        repeat (20) @(posedge clk);
      end
    end

    // R7: continuation during long hold
    start_xfer(0, 2, 0);
    pulse_done(1'b0);
    repeat (30) @(posedge clk);
    orr = n_rise; og = n_go; oc = n_res; of = n_fall;
    #1 start_req = 1'b1;
    while (n_res == oc) @(posedge clk);
    #1 start_req = 1'b0;
    repeat (3) @(posedge clk);
    chk(n_rise == orr && n_fall == of && cs_n == 1'b0, "R7 select not toggled", n_rise - orr, 0);
    chk(n_go == og, "R7 no clk_go on resume", n_go - og, 0);
    chk(n_res == oc + 1, "R7 single resume pulse", n_res - oc, 1);
    pulse_done(1'b0);
    wait_rise(orr);
    chk(rel_ticks == 64, "R7 release restarts after resume", rel_ticks, 64);
    repeat (20) @(posedge clk);

    // R4 / R5: never release, then forced release
    for (int k = 0; k < 2; k++) begin
      automatic int code = (k == 0) ? 4 : 7;
      start_xfer(1, code, 2);
      pulse_done(1'b0);
      orr = n_rise;
      repeat (900) @(posedge clk);
      chk(n_rise == orr && cs_n == 1'b0, "R4 select held indefinitely", n_rise - orr, 0);
      @(posedge clk); #1 force_release = 1'b1;
      ft = 0;
      while (1) begin
        @(negedge clk);
        if (cs_n) break;
        if (tick) ft++;
      end
      @(posedge clk); #1 force_release = 1'b0;
      of = n_fall;
      start_req = 1'b1;
      chk(ft == 1, "R5 forced release on next tick", ft, 1);
      while (n_fall == of) @(posedge clk);
      chk(gap_ticks == 6, "R5 gap after forced release", gap_ticks, 6);
      og = n_go;
      while (n_go == og) @(posedge clk);
      #1 start_req = 1'b0; cfg_release = 3'd0;
      orr = n_rise;
      pulse_done(1'b0);
      wait_rise(orr);
      repeat (20) @(posedge clk);
    end

    // R9: force has no effect in idle and during an active transfer
    of = n_fall;
    @(posedge clk); #1 force_release = 1'b1;
    repeat (30) @(posedge clk);
    #1 force_release = 1'b0;
    chk(n_fall == of && cs_n == 1'b1, "R9 force ignored while idle", n_fall - of, 0);
    start_xfer(0, 0, 0);
    orr = n_rise;
    @(posedge clk); #1 force_release = 1'b1;
    repeat (30) @(posedge clk);
    #1 force_release = 1'b0;
    chk(n_rise == orr && cs_n == 1'b0, "R9 force ignored while active", n_rise - orr, 0);
    pulse_done(1'b0);
    wait_rise(orr);
    chk(rel_ticks == 1, "R3 release after ignored force", rel_ticks, 1);
    repeat (20) @(posedge clk);

    // R9: force beats continuation in hold
    start_xfer(0, 3, 0);
    pulse_done(1'b0);
    repeat (6) @(posedge clk);
    oc = n_res; orr = n_rise;
    #1 force_release = 1'b1; start_req = 1'b1;
    wait_rise(orr);
    #1 force_release = 1'b0;
    chk(n_res == oc, "R9 force has priority over resume", n_res - oc, 0);
    og = n_go;
    while (n_go == og) @(posedge clk);
    #1 start_req = 1'b0; cfg_release = 3'd0;
    orr = n_rise;
    pulse_done(1'b0);
    wait_rise(orr);
    repeat (10) @(posedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule